// File: doc/BRIEF.md
# Parallel-Translate Read Cache

This block is a direct-mapped read cache for a 32-bit virtual address space. The line index is taken only from the part of the address that lies inside a 4 KB page, and translation never changes those bits. So the line array read and the translation lookup run in the same cycle, and neither waits for the other. Only the final tag compare uses the translated address. Each stored tag is a physical page number. A hit needs the addressed line to be valid and its tag to equal the physical page number that the translation buffer returns at that moment.

A CPU issues one read at a time with a valid/ready handshake. In the cycle after acceptance it gets one of three responses: hit (with the 32-bit word), cache miss, or translation miss. After a cache miss the block asks an external memory for the whole 128-byte physical line. When the line arrives the block writes it in, then answers the same access again, this time as a hit. Software loads the 8-entry fully associative translation buffer through a slot-addressed port. A flush input invalidates every line and every translation in one cycle.

Top module: `vipt_cache`

## Requirements
- R1: Address fields: bits [31:12] are the virtual page number, bits [11:7] select one of 32 lines, and bits [6:2] select one of 32 words in the line. Word w is bits [32w+31:32w] of the line.
- R2: A request is accepted at a clock edge where reqValid and reqReady are both high. The response (rspValid high) is present for exactly the cycle that follows. reqReady is high only when no access is in progress.
- R3: The translation buffer has 8 fully associative entries. If no valid entry matches the page number, the response has rspTlbMiss=1 and rspHit=0, and no refill is requested.
- R4: A hit needs a valid line whose stored physical tag equals the page number from the translation buffer. Otherwise, with a valid translation, the response is a cache miss (rspHit=0, rspTlbMiss=0).
- R5: On a hit, rspData is the word that bits [6:2] select from the indexed line.
- R6: In the cycle after a cache-miss response, fillReq goes high with fillAddr = {physical page, line index, 7'b0}. Both stay unchanged until fillValid is seen.
- R7: In a cycle where fillReq and fillValid are both high, fillLine is written as the line together with its tag and valid bit. The next cycle carries a replayed response with rspHit=1 and the requested word. After that the block is idle.
- R8: Two virtual pages that translate to the same physical page share the cached line. Two physical pages whose lines have the same index evict each other.
- R9: A one-cycle flush pulse invalidates all lines and all translation entries. A request that follows gets a translation miss. Once the translation is reloaded, the earlier line misses.
- R10: After reset no line or translation is valid, reqReady=1, rspValid=0 and fillReq=0.
- R11: A load through the translation port overwrites the addressed slot. The new mapping takes effect for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines and translations |
| reqValid | input | 1 | Read request valid |
| reqVaddr | input | 32 | Virtual byte address of the read |
| reqReady | output | 1 | Block can accept a request |
| rspValid | output | 1 | Response present this cycle |
| rspHit | output | 1 | Response is a hit, rspData valid |
| rspTlbMiss | output | 1 | Response is a translation miss |
| rspData | output | 32 | Word read on a hit |
| tlbWe | input | 1 | Load one translation entry |
| tlbSlot | input | 3 | Entry slot to load |
| tlbVpn | input | 20 | Virtual page number to load |
| tlbPpn | input | 20 | Physical page number to load |
| fillReq | output | 1 | Line refill request |
| fillAddr | output | 32 | Physical line address of the refill |
| fillValid | input | 1 | Refill line present |
| fillLine | input | 1024 | Refill line data, word 0 in the low bits |

## Verification
The main function is driven with several address patterns, each aimed at one behaviour. A cold line followed by a read of another word in the same line separates miss-then-replay from a plain hit, and checks that word selection uses bits [6:2]. A second virtual page mapped to the same physical page checks that the physical tag is compared, not the virtual one. A third page with the same index but a different physical page shows eviction by conflict. Unmapped pages, a flush, and the overwrite of a slot then separate a translation miss from a cache miss, and show that an old line cannot survive a flush.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2,
    ST_REPLAY = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // register the incoming virtual address
    logic latchPpn;   // hold the translated page for the refill
    logic fillWrite;  // write returned line, tag and valid bit
  } ctrlStrobes_t;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int PN_W    = 20,
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              we,
  input  logic [SLOT_W-1:0] wSlot,
  input  logic [PN_W-1:0]   wVpn,
  input  logic [PN_W-1:0]   wPpn,
  input  logic [PN_W-1:0]   lookVpn,
  output logic              hit,
  output logic [PN_W-1:0]   ppn
);
  logic [ENTRIES-1:0] entValid;
  logic [PN_W-1:0]    entVpn [ENTRIES];
  logic [PN_W-1:0]    entPpn [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN || flush) begin
        entValid[i] <= 1'b0;
      end else if (we && wSlot == SLOT_W'(i)) begin
        entValid[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we && wSlot == SLOT_W'(i)) begin
        entVpn[i] <= wVpn;
        entPpn[i] <= wPpn;
      end
    end

    assign match[i] = entValid[i] && (entVpn[i] == lookVpn);
  end

  // lowest matching slot wins
  always_comb begin
    hit = 1'b0;
    ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        ppn = entPpn[i];
      end
    end
  end
endmodule

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_OFF_W = 7,
  parameter int WORD_W     = 32,
  parameter int TLB_N      = 8,
  localparam int PN_W      = VA_W - PAGE_OFF_W,
  localparam int IDX_W     = PAGE_OFF_W - LINE_OFF_W,
  localparam int LINES     = 1 << IDX_W,
  localparam int LINE_W    = 8 << LINE_OFF_W,
  localparam int BSEL_W    = $clog2(WORD_W / 8),
  localparam int WSEL_W    = LINE_OFF_W - BSEL_W,
  localparam int WSHIFT    = $clog2(WORD_W),
  localparam int LBIT_W    = $clog2(LINE_W),
  localparam int SLOT_W    = $clog2(TLB_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  ctrlStrobes_t      strobes,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              tlbWe,
  input  logic [SLOT_W-1:0] tlbSlot,
  input  logic [PN_W-1:0]   tlbVpn,
  input  logic [PN_W-1:0]   tlbPpn,
  input  logic [LINE_W-1:0] fillLine,
  output logic              tlbHit,
  output logic              cacheHit,
  output logic [WORD_W-1:0] rdWord,
  output logic [VA_W-1:0]   fillAddr
);
  logic [VA_W-1:0]   vaddrReg;
  logic [PN_W-1:0]   ppnReg;
  logic [PN_W-1:0]   xlatPpn;
  logic [LINES-1:0]  lineValid;
  logic [PN_W-1:0]   tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];

  logic [IDX_W-1:0]  lineIdx;
  logic [WSEL_W-1:0] wordSel;
  logic [LBIT_W-1:0] bitBase;
  logic [PN_W-1:0]   virtPage;

  assign virtPage = vaddrReg[VA_W-1 -: PN_W];
  assign lineIdx  = vaddrReg[PAGE_OFF_W-1 -: IDX_W];
  assign wordSel  = vaddrReg[LINE_OFF_W-1 -: WSEL_W];
  assign bitBase  = {wordSel, {WSHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrReg <= '0;
    end else if (strobes.capture) begin
      vaddrReg <= reqVaddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ppnReg <= '0;
    end else if (strobes.latchPpn) begin
      ppnReg <= xlatPpn;
    end
  end

  // translation runs beside the array read
  vipt_tlb #(
    .PN_W   (PN_W),
    .ENTRIES(TLB_N)
  ) u_tlb (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (flush),
    .we     (tlbWe),
    .wSlot  (tlbSlot),
    .wVpn   (tlbVpn),
    .wPpn   (tlbPpn),
    .lookVpn(virtPage),
    .hit    (tlbHit),
    .ppn    (xlatPpn)
  );

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      lineValid <= '0;
    end else if (strobes.fillWrite) begin
      lineValid[lineIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillWrite) begin
      tagArr[lineIdx]  <= ppnReg;
      dataArr[lineIdx] <= fillLine;
    end
  end

  assign cacheHit = tlbHit && lineValid[lineIdx] && (tagArr[lineIdx] == xlatPpn);
  assign rdWord   = dataArr[lineIdx][bitBase +: WORD_W];
  assign fillAddr = {ppnReg, lineIdx, {LINE_OFF_W{1'b0}}};
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         tlbHit,
  input  logic         cacheHit,
  input  logic         fillValid,
  output logic         reqReady,
  output logic         rspValid,
  output logic         rspHit,
  output logic         rspTlbMiss,
  output logic         fillReq,
  output ctrlStrobes_t strobes
);
  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        strobes.capture = reqValid;
        if (reqValid) nextState = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (tlbHit && !cacheHit) begin
          strobes.latchPpn = 1'b1;
          nextState        = ST_FILL;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (fillValid) begin
          strobes.fillWrite = 1'b1;
          nextState         = ST_REPLAY;
        end
      end
      ST_REPLAY: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign reqReady   = (state == ST_IDLE);
  assign fillReq    = (state == ST_FILL);
  assign rspValid   = (state == ST_LOOKUP) || (state == ST_REPLAY);
  assign rspHit     = rspValid && cacheHit;
  assign rspTlbMiss = rspValid && !tlbHit;
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_OFF_W = 7,
  parameter int WORD_W     = 32,
  parameter int TLB_N      = 8,
  localparam int PN_W      = VA_W - PAGE_OFF_W,
  localparam int LINE_W    = 8 << LINE_OFF_W,
  localparam int SLOT_W    = $clog2(TLB_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspTlbMiss,
  output logic [WORD_W-1:0] rspData,
  input  logic              tlbWe,
  input  logic [SLOT_W-1:0] tlbSlot,
  input  logic [PN_W-1:0]   tlbVpn,
  input  logic [PN_W-1:0]   tlbPpn,
  output logic              fillReq,
  output logic [VA_W-1:0]   fillAddr,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine
);
  ctrlStrobes_t strobes;
  logic         tlbHit;
  logic         cacheHit;

  vipt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .tlbHit    (tlbHit),
    .cacheHit  (cacheHit),
    .fillValid (fillValid),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspTlbMiss(rspTlbMiss),
    .fillReq   (fillReq),
    .strobes   (strobes)
  );

  vipt_datapath #(
    .VA_W      (VA_W),
    .PAGE_OFF_W(PAGE_OFF_W),
    .LINE_OFF_W(LINE_OFF_W),
    .WORD_W    (WORD_W),
    .TLB_N     (TLB_N)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (flush),
    .strobes (strobes),
    .reqVaddr(reqVaddr),
    .tlbWe   (tlbWe),
    .tlbSlot (tlbSlot),
    .tlbVpn  (tlbVpn),
    .tlbPpn  (tlbPpn),
    .fillLine(fillLine),
    .tlbHit  (tlbHit),
    .cacheHit(cacheHit),
    .rdWord  (rspData),
    .fillAddr(fillAddr)
  );
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspTlbMiss,
  input logic            tlbWe,
  input logic            fillReq,
  input logic [VA_W-1:0] fillAddr,
  input logic            fillValid
);
  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!rspValid && !fillReq));

  p_kind_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspHit && rspTlbMiss));

  p_tlbmiss_nofill_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTlbMiss) |=> !fillReq);

  p_fill_after_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fillReq) |-> $past(rspValid && !rspHit && !rspTlbMiss));

  p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillValid) |=> (fillReq && $stable(fillAddr)));

  p_replay_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillValid && !flush && !tlbWe) |=> (rspValid && rspHit));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !tlbWe) |=> (!rspValid || rspTlbMiss));
endmodule

bind vipt_cache vipt_cache_chk #(.VA_W(VA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flush     (flush),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspTlbMiss(rspTlbMiss),
  .tlbWe     (tlbWe),
  .fillReq   (fillReq),
  .fillAddr  (fillAddr),
  .fillValid (fillValid)
);

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
  localparam int NV      = 10;
  localparam int MEM_LAT = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flush = 1'b0;
  logic          reqValid = 1'b0;
  logic [31:0]   reqVaddr = '0;
  logic          reqReady, rspValid, rspHit, rspTlbMiss;
  logic [31:0]   rspData;
  logic          tlbWe = 1'b0;
  logic [2:0]    tlbSlot = '0;
  logic [19:0]   tlbVpn = '0, tlbPpn = '0;
  logic          fillReq;
  logic [31:0]   fillAddr;
  logic          fillValid = 1'b0;
  logic [1023:0] fillLine = '0;

  int checks = 0;
  int failures = 0;
  int fillCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vipt_cache u_vipt_cache (
    .clk(clk), .rstN(rstN), .flush(flush),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspHit(rspHit), .rspTlbMiss(rspTlbMiss), .rspData(rspData),
    .tlbWe(tlbWe), .tlbSlot(tlbSlot), .tlbVpn(tlbVpn), .tlbPpn(tlbPpn),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid), .fillLine(fillLine)
  );

  // kinds: 0 translation miss, 1 hit, 2 miss then replayed hit
  localparam logic [31:0] V_ADDR [NV] = '{
    {20'h00010, 5'd3,  7'h04}, {20'h00010, 5'd3,  7'h7C}, {20'h12345, 5'd3, 7'h00},
    {20'h0F0F0, 5'd3,  7'h08}, {20'h00010, 5'd3,  7'h04}, {20'hABCDE, 5'd3, 7'h00},
    {20'hFFFFF, 5'd31, 7'h40}, {20'hFFFFF, 5'd31, 7'h44}, {20'h0F0F0, 5'd0, 7'h00},
    {20'h0F0F0, 5'd0,  7'h7C}};
  localparam logic [19:0] V_PPN [NV] = '{
    20'h00ABC, 20'h00ABC, 20'h00ABC, 20'h55555, 20'h00ABC,
    20'h00000, 20'h00001, 20'h00001, 20'h55555, 20'h55555};
  localparam logic [1:0] V_KIND [NV] = '{2, 1, 1, 2, 2, 0, 2, 1, 2, 1};

  function automatic logic [31:0] expWord(input logic [24:0] pline, input logic [4:0] w);
    return {2'b10, pline, w};
  endfunction

  function automatic logic [1023:0] makeLine(input logic [24:0] pline);
    logic [1023:0] l;
    for (int w = 0; w < 32; w++) l[32*w +: 32] = expWord(pline, 5'(w));
    return l;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadTlb(input logic [2:0] slot, input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    tlbWe = 1'b1; tlbSlot = slot; tlbVpn = vpn; tlbPpn = ppn;
    @(negedge clk);
    tlbWe = 1'b0;
  endtask

  // memory model: answers a refill after MEM_LAT waiting cycles
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (fillValid) fillValid = 1'b0;
      else if (fillReq) begin
        if (waitCnt == MEM_LAT) begin
          fillLine  = makeLine(fillAddr[31:7]);
          fillValid = 1'b1;
          fillCount++;
          waitCnt = 0;
        end else waitCnt++;
      end
    end
  end

  // one read; kind as in the vector table
  task automatic doRead(input logic [31:0] va, input logic [19:0] ppn, input logic [1:0] kind, input string tag);
    logic [31:0] expData;
    logic [31:0] expFill;
    int startFills;
    expData = expWord({ppn, va[11:7]}, va[6:2]);
    expFill = {ppn, va[11:7], 7'b0};
    startFills = fillCount;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, {tag, " R2 response one cycle after accept"}, 32'(rspValid), 32'd1);
    if (kind == 2'd0) begin
      check(rspTlbMiss === 1'b1 && rspHit === 1'b0, {tag, " R3 translation miss"},
            {30'd0, rspTlbMiss, rspHit}, 32'd2);
    end else if (kind == 2'd1) begin
      check(rspHit === 1'b1, {tag, " R4 hit"}, 32'(rspHit), 32'd1);
      check(rspData === expData, {tag, " R5 R1 word select"}, rspData, expData);
    end else begin
      check(rspHit === 1'b0 && rspTlbMiss === 1'b0, {tag, " R4 cache miss"},
            {30'd0, rspTlbMiss, rspHit}, 32'd0);
      @(negedge clk);
      check(fillReq === 1'b1 && fillAddr === expFill, {tag, " R6 refill address"}, fillAddr, expFill);
      for (int i = 0; i < 20 && !rspValid; i++) begin
        if (!rspValid && !fillValid)
          check(fillReq === 1'b1 && fillAddr === expFill, {tag, " R6 refill held"}, fillAddr, expFill);
        @(negedge clk);
      end
      check(rspValid === 1'b1 && rspHit === 1'b1, {tag, " R7 replay hit"}, {30'd0, rspValid, rspHit}, 32'd3);
      check(rspData === expData, {tag, " R7 replay word"}, rspData, expData);
    end
    @(negedge clk);
    check(rspValid === 1'b0 && reqReady === 1'b1, {tag, " R2 idle after response"},
          {30'd0, rspValid, reqReady}, 32'd1);
    if (kind != 2'd2)
      check(fillCount == startFills, {tag, " R3 no refill"}, 32'(fillCount - startFills), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1 && rspValid === 1'b0 && fillReq === 1'b0, "R10 reset state",
          {29'd0, reqReady, rspValid, fillReq}, 32'd4);
    // nothing valid after reset: translation miss
    doRead({20'h00010, 5'd3, 7'h04}, 20'h0, 2'd0, "R10 empty");

    loadTlb(3'd0, 20'h00010, 20'h00ABC);
    loadTlb(3'd1, 20'h12345, 20'h00ABC);
    loadTlb(3'd2, 20'h0F0F0, 20'h55555);
    loadTlb(3'd7, 20'hFFFFF, 20'h00001);

    // table walk: R1 R4 R5 R8 across cold, same-line, alias, conflict, unmapped
    for (int v = 0; v < NV; v++)
      doRead(V_ADDR[v], V_PPN[v], V_KIND[v], $sformatf("vec%0d R8", v));

    // R9 flush empties translations and lines
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    doRead({20'h00010, 5'd3, 7'h7C}, 20'h0, 2'd0, "R9 after flush");
    loadTlb(3'd0, 20'h00010, 20'h00ABC);
    doRead({20'h00010, 5'd3, 7'h7C}, 20'h00ABC, 2'd2, "R9 line gone");

    // R11 overwrite slot 2 so a new page maps onto the cached physical page
    loadTlb(3'd2, 20'h0F0F0, 20'h00ABC);
    doRead({20'h0F0F0, 5'd3, 7'h10}, 20'h00ABC, 2'd1, "R11 slot overwrite");
    doRead({20'h0F0F0, 5'd0, 7'h00}, 20'h00ABC, 2'd2, "R11 old mapping gone");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule